// File: doc/BRIEF.md
# Power State and Wakeup Controller

This block keeps track of the system power state: Run, Doze or Sleep. It produces the enable for the processor clock and decides which events bring the system back to Run. A bus write strobe aimed at the doze address moves the system from Run to Doze. A strobe aimed at the sleep address moves it from Run to Sleep. In Doze only the processor clock stops. Sleep also switches off the serial receiver enable.

Wakeup can come from pending interrupt requests that are enabled by their mask bits, from an 8-line keypad port, or, in Sleep only, from an active-high external wake pin. The keypad lines are ORed into a key-detect request. A narrow-keypad select drops the top two lines from that OR, so those lines can serve as general I/O. With the force-wake control set, a keypress wakes the system even when the key interrupt is masked. In that case the processor simply resumes and no service is requested. On every return to Run the block issues a one-cycle service pulse if an enabled request is waiting.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `pwr_state` is 0 (Run), `cpu_clk_en` is 1, `uart_en` is 1 and `svc_pulse` is 0.
- R2: A `doze_wr` strobe in Run sets `pwr_state` to 1 (Doze) on the next clock edge. In Doze `cpu_clk_en` is 0 and `uart_en` stays 1.
- R3: A `sleep_wr` strobe in Run sets `pwr_state` to 2 (Sleep) on the next edge, with `cpu_clk_en` 0 and `uart_en` 0. When both strobes are high together, Sleep is chosen.
- R4: In Doze, any bit set in both `irq_pend` and `irq_en` returns the block to Run on the next edge, with `svc_pulse` high for that first Run cycle.
- R5: The wake pin leaves Doze unchanged. In Sleep, after its two-stage synchronizer, it moves the block to Run three edges after it rises, with no service pulse.
- R6: With `kbd_narrow` 0, all 8 `kbd_in` lines feed the key request and key wake. With `kbd_narrow` 1, only bits 5:0 are used and bits 7:6 have no effect.
- R7: With `kbd_force` 0 and `kbd_irq_en` 1, a keypress wakes Doze or Sleep three edges after the press and raises `svc_pulse`.
- R8: With `kbd_force` 1 and `kbd_irq_en` 0, a keypress still wakes the block three edges after the press, and `svc_pulse` stays 0.
- R9: With `kbd_force` 0 and `kbd_irq_en` 0, a keypress does not wake the block. A request whose `irq_en` bit is 0 does not wake it either.
- R10: `doze_wr` and `sleep_wr` have no effect outside Run.
- R11: `svc_pulse` lasts exactly one cycle and occurs only on the first cycle of Run after Doze or Sleep.
- R12: `uart_en` returns to 1 on the same edge on which Sleep exits to Run. Sleep always exits to Run and never to Doze.
- R13: `kbd_irq` follows the selected key lines two edges after they change, in every state and whatever the mask and force bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Synchronous reset, active low |
| doze_wr | input | 1 | Bus write strobe to the doze address |
| sleep_wr | input | 1 | Bus write strobe to the sleep address |
| irq_pend | input | NIRQ | Pending interrupt requests, key request excluded |
| irq_en | input | NIRQ | Interrupt mask, 1 = enabled |
| kbd_irq_en | input | 1 | Key interrupt mask bit, 1 = enabled |
| wake_pin | input | 1 | External wake, active high, asynchronous |
| kbd_in | input | KBD_W | Keypad port lines, asynchronous |
| kbd_force | input | 1 | Keypress wakes even when masked |
| kbd_narrow | input | 1 | Use only the low 6 keypad lines |
| cpu_clk_en | output | 1 | Processor clock enable |
| kbd_irq | output | 1 | Key-detect interrupt request |
| svc_pulse | output | 1 | One-cycle pulse: wake with request to service |
| pwr_state | output | 2 | 0 Run, 1 Doze, 2 Sleep |
| uart_en | output | 1 | Serial receiver enable |

## Verification
The assertions assume that `irq_pend`, `irq_en`, the mask, force and narrow bits and the two write strobes are synchronous to `clk`. Only `kbd_in` and `wake_pin` may change at any time, and they go through the synchronizers before reaching any checked logic. The Doze-hold property also assumes that a key request visible on `kbd_irq` is the only key input to the wake decision. The bench keeps within these assumptions by driving every input on the falling edge. It waits out the synchronizer latency before expecting a key or pin effect.

// File: rtl/pwr_wake_pkg.sv
// Package: shared state encoding for the power state and wakeup controller.
// Assumes: the encoding is visible at the top-level port, so values are fixed.
package pwr_wake_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_DOZE  = 2'd1,
        PS_SLEEP = 2'd2
    } pstate_e;

    localparam int unsigned PSTATE_W = 2;

endpackage

// File: rtl/pwr_sync.sv
// Module: multi-bit, multi-stage synchronizer for asynchronous level inputs.
// Assumes: each bit is an independent slow level; no bus coherency is needed.
module pwr_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the asynchronous sample through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_async;
            for (int unsigned s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_kbd_or.sv
// Module: key-detect combiner. It ORs the synchronized keypad lines,
// optionally restricted to the low NARROW_W lines.
// Assumes: the inputs are already synchronized to clk.
module pwr_kbd_or #(
    parameter int unsigned KBD_W    = 8,
    parameter int unsigned NARROW_W = 6
) (
    input  logic [KBD_W-1:0] kbd_s,
    input  logic             narrow,
    output logic             key_any
);

    logic [KBD_W-1:0] sel_mask;

    // Build the line-select mask: a bit is used if it is below the narrow
    // width, or if the full width is selected.
    for (genvar i = 0; i < KBD_W; i++) begin : g_sel
        if (i < NARROW_W) begin : g_low
            assign sel_mask[i] = 1'b1;
        end else begin : g_high
            assign sel_mask[i] = ~narrow;
        end
    end

    // Reduce the selected lines to one key-detect level.
    always_comb begin
        key_any = |(kbd_s & sel_mask);
    end

endmodule

// File: rtl/pwr_wake_eval.sv
// Module: wake source evaluation. It decides whether the current low-power
// state must exit, and whether the exit carries a request to service.
// Assumes: all inputs are synchronous to clk.
module pwr_wake_eval
    import pwr_wake_pkg::*;
#(
    parameter int unsigned NIRQ = 8
) (
    input  pstate_e         state,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            key_any,
    input  logic            kbd_irq_en,
    input  logic            kbd_force,
    input  logic            wake_s,
    output logic            wake_req,
    output logic            svc_req
);

    logic irq_hit;
    logic key_svc;
    logic key_force_hit;
    logic pin_hit;

    // Classify every wake source.
    always_comb begin
        irq_hit       = |(irq_pend & irq_en);
        key_svc       = key_any & kbd_irq_en;
        key_force_hit = key_any & kbd_force;
        pin_hit       = wake_s & (state == PS_SLEEP);
    end

    // Combine the sources into the exit decision and the service request.
    always_comb begin
        wake_req = irq_hit | key_svc | key_force_hit | pin_hit;
        svc_req  = irq_hit | key_svc;
    end

endmodule

// File: rtl/pwr_state_fsm.sv
// Module: power state register with the service pulse.
// Run -> Doze on doze strobe, Run -> Sleep on sleep strobe (sleep wins),
// Doze/Sleep -> Run on wake request.
// Assumes: the strobes are single-cycle or level, synchronous to clk.
module pwr_state_fsm
    import pwr_wake_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    doze_wr,
    input  logic    sleep_wr,
    input  logic    wake_req,
    input  logic    svc_req,
    output pstate_e state,
    output logic    svc_pulse
);

    pstate_e state_q;
    pstate_e state_d;
    logic    svc_q;
    logic    svc_d;

    // Next-state and service pulse decision.
    always_comb begin
        state_d = state_q;
        svc_d   = 1'b0;
        unique case (state_q)
            PS_RUN: begin
                if (sleep_wr) begin
                    state_d = PS_SLEEP;
                end else if (doze_wr) begin
                    state_d = PS_DOZE;
                end
            end
            PS_DOZE, PS_SLEEP: begin
                if (wake_req) begin
                    state_d = PS_RUN;
                    svc_d   = svc_req;
                end
            end
            default: begin
                state_d = PS_RUN;
            end
        endcase
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            svc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            svc_q   <= svc_d;
        end
    end

    assign state     = state_q;
    assign svc_pulse = svc_q;

endmodule

// File: rtl/pwr_wake_ctrl.sv
// Module: power state and wakeup controller (top).
// It synchronizes the keypad and wake pin, combines the key lines,
// evaluates wake sources and holds the power state.
// Assumes: bus strobes and interrupt vectors are synchronous to clk;
// kbd_in and wake_pin are asynchronous.
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int unsigned NIRQ        = 8,
    parameter int unsigned KBD_W       = 8,
    parameter int unsigned NARROW_W    = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             doze_wr,
    input  logic             sleep_wr,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic             kbd_irq_en,
    input  logic             wake_pin,
    input  logic [KBD_W-1:0] kbd_in,
    input  logic             kbd_force,
    input  logic             kbd_narrow,
    output logic             cpu_clk_en,
    output logic             kbd_irq,
    output logic             svc_pulse,
    output logic [1:0]       pwr_state,
    output logic             uart_en
);

    localparam int unsigned ASYNC_W = KBD_W + 1;

    logic [ASYNC_W-1:0] async_raw;
    logic [ASYNC_W-1:0] async_s;
    logic [KBD_W-1:0]   kbd_s;
    logic               wake_s;
    logic               key_any;
    logic               wake_req;
    logic               svc_req;
    pstate_e            state;

    assign async_raw = {wake_pin, kbd_in};

    pwr_sync #(
        .W      (ASYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (async_raw),
        .q_sync  (async_s)
    );

    assign kbd_s  = async_s[KBD_W-1:0];
    assign wake_s = async_s[KBD_W];

    pwr_kbd_or #(
        .KBD_W    (KBD_W),
        .NARROW_W (NARROW_W)
    ) u_kbd (
        .kbd_s   (kbd_s),
        .narrow  (kbd_narrow),
        .key_any (key_any)
    );

    pwr_wake_eval #(
        .NIRQ (NIRQ)
    ) u_eval (
        .state      (state),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .key_any    (key_any),
        .kbd_irq_en (kbd_irq_en),
        .kbd_force  (kbd_force),
        .wake_s     (wake_s),
        .wake_req   (wake_req),
        .svc_req    (svc_req)
    );

    pwr_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .doze_wr   (doze_wr),
        .sleep_wr  (sleep_wr),
        .wake_req  (wake_req),
        .svc_req   (svc_req),
        .state     (state),
        .svc_pulse (svc_pulse)
    );

    // Drive the state-derived enables and the key request.
    always_comb begin
        cpu_clk_en = (state == PS_RUN);
        uart_en    = (state != PS_SLEEP);
        kbd_irq    = key_any;
        pwr_state  = state;
    end

endmodule

// File: rtl/pwr_wake_chk.sv
// Module: protocol checker for pwr_wake_ctrl, attached by bind.
// Assumes: synchronous inputs change only between clock edges.
module pwr_wake_chk #(
    parameter int unsigned NIRQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            doze_wr,
    input logic            sleep_wr,
    input logic [NIRQ-1:0] irq_pend,
    input logic [NIRQ-1:0] irq_en,
    input logic            cpu_clk_en,
    input logic            kbd_irq,
    input logic            svc_pulse,
    input logic [1:0]      pwr_state,
    input logic            uart_en
);

    localparam logic [1:0] S_RUN   = 2'd0;
    localparam logic [1:0] S_DOZE  = 2'd1;
    localparam logic [1:0] S_SLEEP = 2'd2;

    p_doze_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == S_RUN && doze_wr && !sleep_wr) |=> (pwr_state == S_DOZE && !cpu_clk_en && uart_en));

    p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == S_RUN && sleep_wr) |=> (pwr_state == S_SLEEP && !cpu_clk_en && !uart_en));

    p_doze_irq_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == S_DOZE && (|(irq_pend & irq_en))) |=> (pwr_state == S_RUN && svc_pulse));

    // R5, R9, R10: with no enabled request and no key request, Doze holds
    p_doze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == S_DOZE && !(|(irq_pend & irq_en)) && !kbd_irq) |=> (pwr_state == S_DOZE));

    p_svc_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pulse |=> !svc_pulse);

    p_svc_on_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pulse |-> (pwr_state == S_RUN && $past(pwr_state) != S_RUN));

    p_sleep_exit_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == S_SLEEP) |=> (pwr_state == S_SLEEP || (pwr_state == S_RUN && uart_en)));

    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd3));

endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.NIRQ(NIRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .doze_wr    (doze_wr),
    .sleep_wr   (sleep_wr),
    .irq_pend   (irq_pend),
    .irq_en     (irq_en),
    .cpu_clk_en (cpu_clk_en),
    .kbd_irq    (kbd_irq),
    .svc_pulse  (svc_pulse),
    .pwr_state  (pwr_state),
    .uart_en    (uart_en)
);

// File: tb/pwr_wake_ctrl_bench.sv
// Directed bench for pwr_wake_ctrl: one task per scenario, inputs driven
// and outputs sampled on the falling edge.
module pwr_wake_ctrl_bench;

    localparam int NIRQ = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            doze_wr, sleep_wr;
    logic [NIRQ-1:0] irq_pend, irq_en;
    logic            kbd_irq_en, wake_pin, kbd_force, kbd_narrow;
    logic [7:0]      kbd_in;
    logic            cpu_clk_en, kbd_irq, svc_pulse, uart_en;
    logic [1:0]      pwr_state;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwr_wake_ctrl #(.NIRQ(NIRQ)) u_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .doze_wr(doze_wr), .sleep_wr(sleep_wr),
        .irq_pend(irq_pend), .irq_en(irq_en), .kbd_irq_en(kbd_irq_en),
        .wake_pin(wake_pin), .kbd_in(kbd_in), .kbd_force(kbd_force),
        .kbd_narrow(kbd_narrow), .cpu_clk_en(cpu_clk_en), .kbd_irq(kbd_irq),
        .svc_pulse(svc_pulse), .pwr_state(pwr_state), .uart_en(uart_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        doze_wr = 0; sleep_wr = 0; irq_pend = '0; irq_en = '0;
        kbd_irq_en = 0; wake_pin = 0; kbd_in = '0; kbd_force = 0; kbd_narrow = 0;
    endtask

    task automatic to_doze();
        doze_wr = 1; step(1); doze_wr = 0;
    endtask

    task automatic to_sleep();
        sleep_wr = 1; step(1); sleep_wr = 0;
    endtask

    // Leave Doze/Sleep through an enabled interrupt and settle.
    task automatic irq_exit();
        irq_pend = 8'h01; irq_en = 8'h01; step(1);
        irq_pend = '0; irq_en = '0; step(1);
    endtask

    task automatic t_reset();
        rst_n = 0; quiet(); step(3);
        check("R1", "state in reset", pwr_state, 0);
        rst_n = 1; step(1);
        check("R1", "state", pwr_state, 0);
        check("R1", "clk_en", cpu_clk_en, 1);
        check("R1", "uart_en", uart_en, 1);
        check("R1", "svc", svc_pulse, 0);
    endtask

    task automatic t_doze_irq();
        to_doze();
        check("R2", "state", pwr_state, 1);
        check("R2", "clk_en", cpu_clk_en, 0);
        check("R2", "uart_en", uart_en, 1);
        irq_pend = 8'h10; irq_en = 8'h00; step(2);
        check("R9", "masked irq keeps doze", pwr_state, 1);
        irq_en = 8'h10; step(1);
        check("R4", "irq exit state", pwr_state, 0);
        check("R4", "svc pulse", svc_pulse, 1);
        check("R4", "clk_en", cpu_clk_en, 1);
        irq_pend = '0; irq_en = '0; step(1);
        check("R11", "svc one cycle", svc_pulse, 0);
    endtask

    task automatic t_pin();
        to_doze();
        wake_pin = 1; step(4);
        check("R5", "pin ignored in doze", pwr_state, 1);
        wake_pin = 0; step(3);
        irq_exit();
        to_sleep();
        check("R3", "state", pwr_state, 2);
        check("R3", "clk_en", cpu_clk_en, 0);
        check("R3", "uart_en", uart_en, 0);
        wake_pin = 1; step(2);
        check("R5", "not yet out", pwr_state, 2);
        step(1);
        check("R5", "pin exits sleep", pwr_state, 0);
        check("R5", "no svc on pin", svc_pulse, 0);
        check("R12", "uart_en back", uart_en, 1);
        wake_pin = 0; step(3);
    endtask

    task automatic t_both_writes();
        doze_wr = 1; sleep_wr = 1; step(1); doze_wr = 0; sleep_wr = 0;
        check("R3", "sleep wins", pwr_state, 2);
        doze_wr = 1; step(2); doze_wr = 0;
        check("R10", "doze strobe in sleep", pwr_state, 2);
        irq_exit();
        check("R12", "exit to run", pwr_state, 0);
        to_doze();
        sleep_wr = 1; step(2); sleep_wr = 0;
        check("R10", "sleep strobe in doze", pwr_state, 1);
        check("R10", "uart_en kept", uart_en, 1);
        irq_exit();
    endtask

    task automatic t_kbd_select();
        kbd_narrow = 1; kbd_in = 8'hC0; step(3);
        check("R6", "narrow ignores 7:6", kbd_irq, 0);
        kbd_narrow = 0; step(1);
        check("R6", "wide uses 7:6", kbd_irq, 1);
        kbd_in = 8'h00; step(1);
        check("R13", "one edge later still set", kbd_irq, 1);
        step(1);
        check("R13", "two edges later clear", kbd_irq, 0);
        kbd_narrow = 1; kbd_force = 1; to_doze();
        kbd_in = 8'h80; step(4);
        check("R6", "narrow high line no wake", pwr_state, 1);
        kbd_in = 8'h20; step(2);
        check("R13", "req in doze", kbd_irq, 1);
        step(1);
        check("R6", "low line wakes", pwr_state, 0);
        kbd_in = 0; kbd_narrow = 0; kbd_force = 0; step(3);
    endtask

    task automatic t_kbd_unmasked();
        kbd_irq_en = 1; to_sleep();
        kbd_in = 8'h04; step(2);
        check("R7", "not yet", pwr_state, 2);
        step(1);
        check("R7", "key wakes", pwr_state, 0);
        check("R7", "svc", svc_pulse, 1);
        kbd_in = 0; kbd_irq_en = 0; step(3);
    endtask

    task automatic t_kbd_force();
        kbd_force = 1; to_doze();
        kbd_in = 8'h01; step(3);
        check("R8", "forced wake", pwr_state, 0);
        check("R8", "no svc", svc_pulse, 0);
        kbd_in = 0; kbd_force = 0; step(3);
    endtask

    task automatic t_kbd_blocked();
        to_doze();
        kbd_in = 8'h02; step(4);
        check("R9", "masked key no wake", pwr_state, 1);
        check("R13", "req despite mask", kbd_irq, 1);
        kbd_irq_en = 1; step(1);
        check("R7", "unmask wakes", pwr_state, 0);
        check("R7", "svc", svc_pulse, 1);
        kbd_in = 0; kbd_irq_en = 0; step(3);
    endtask

    initial begin
        t_reset();
        t_doze_irq();
        t_pin();
        t_both_writes();
        t_kbd_select();
        t_kbd_unmasked();
        t_kbd_force();
        t_kbd_blocked();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule